// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit watches one asynchronous external interrupt line and turns a configurable condition on it into an interrupt request for the CPU. A two-bit sense field picks the condition: a held low level, a falling edge or a rising edge. One code of that field is reserved and never produces a request. The line is first passed through a synchroniser and a sample register on the CPU clock, and edges are found by comparing two successive samples. A pulse therefore has to span more than one clock period to be seen.

Edges are remembered in a sticky flag until the CPU acknowledges it. Low-level sensing keeps no memory: the request is armed only when the line is still low at the moment an instruction completes, signalled by a one-cycle strobe, and it holds for every cycle the line stays low. The request driven to the CPU is gated by the source's own enable and by the global interrupt enable. A separate, unclocked wake signal follows a low line directly, so that wake-up logic can use it while the main clock is stopped. Rewriting the sense field while the source is enabled may raise the edge flag on its own, which software avoids by clearing the enable first.

Top module: `extint_sense`

## Requirements
- R1: While `rst` is high and after it is released with `pin_async` high, `irq` and `edge_flag` are 0.
- R2: With `sense_mode` = 2'b10 (falling edge), a high-to-low change on `pin_async` sets `edge_flag`; a low-to-high change does not.
- R3: With `sense_mode` = 2'b11 (rising edge), a low-to-high change on `pin_async` sets `edge_flag`; a high-to-low change does not.
- R4: With `sense_mode` = 2'b01 (reserved), no change or level on `pin_async` sets `edge_flag` or raises `irq`, whatever `insn_done` does.
- R5: With `sense_mode` = 2'b00 (low level), if `pin_async` is low when `insn_done` pulses, `irq` rises and stays 1 for every cycle the line remains low, drops once the line returns high, and `edge_flag` never sets.
- R6: With `sense_mode` = 2'b00, a low line with no `insn_done` pulse raises no request.
- R7: `irq` is 1 only when both `global_ie` and `local_en` are 1 and a flag or level request is pending; each of the other three enable combinations holds `irq` at 0.
- R8: A one-cycle `ack` clears `edge_flag`; when an edge is detected in the same cycle as `ack`, the flag stays set.
- R9: In an edge mode, a pulse lasting two clock periods sets `edge_flag`.
- R10: Changing `sense_mode` into an edge mode (2'b10 or 2'b11) while `local_en` is 1 sets `edge_flag`; the same change with `local_en` at 0 leaves the flag clear and `irq` at 0.
- R11: `level_wake` is 1, without any clock edge, exactly when `sense_mode` = 2'b00, `local_en` = 1 and `pin_async` is low.
- R12: After `pin_async` changes just after a rising clock edge, `edge_flag` rises on the fourth following rising edge (two synchroniser flops, sample, detect) and `irq` on the fifth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | External interrupt line, asynchronous, idles high |
| sense_mode | input | 2 | Sense select: 00 low level, 01 reserved, 10 falling edge, 11 rising edge |
| local_en | input | 1 | Enable (mask) bit of this source |
| global_ie | input | 1 | Global interrupt enable |
| insn_done | input | 1 | One-cycle strobe at instruction completion |
| ack | input | 1 | One-cycle acknowledge that clears the edge flag |
| irq | output | 1 | Registered interrupt request to the CPU |
| edge_flag | output | 1 | Sticky edge-detected flag |
| level_wake | output | 1 | Unclocked low-level wake request |

## Verification
The assertions assume `ack` and `insn_done` are single-cycle strobes driven synchronously, and that `sense_mode` is changed only with `local_en` cleared unless a spurious flag is the point of the test. The bench drives every input on the falling clock edge, holds each line level for many cycles so the synchroniser settles, and rewrites the sense field only with the enable low, except in the one sequence that deliberately provokes the spurious flag.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int  STAGES     = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_sync,
  input  logic [1:0] sense_mode,
  input  logic       local_en,
  input  logic       insn_done,
  output sense_t     mode_q,
  output logic       samp_cur,
  output logic       edge_hit,
  output logic       spur,
  output logic       lvl_req
);
  logic samp_prev;

  // Sample pair: current and previous synchronised value
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_cur  <= IDLE_LEVEL;
      samp_prev <= IDLE_LEVEL;
      mode_q    <= SENSE_LOW;
    end else begin
      samp_cur  <= pin_sync;
      samp_prev <= samp_cur;
      mode_q    <= sense_t'(sense_mode);
    end
  end

  always_comb begin
    unique case (mode_q)
      SENSE_FALL: edge_hit = samp_prev & ~samp_cur;
      SENSE_RISE: edge_hit = ~samp_prev & samp_cur;
      default:    edge_hit = 1'b0;
    endcase
  end

  // Rewriting the sense field into an edge mode while enabled glitches the flag
  assign spur = local_en & sense_mode[1] & (sense_mode != mode_q);

  // Level request: armed at instruction completion, held while the line is low
  always_ff @(posedge clk) begin
    if (rst) lvl_req <= 1'b0;
    else     lvl_req <= (mode_q == SENSE_LOW) & ~samp_cur & (insn_done | lvl_req);
  end
endmodule

// File: rtl/extint_flag.sv
module extint_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_async,
  input  logic [1:0] sense_mode,
  input  logic       local_en,
  input  logic       global_ie,
  input  logic       insn_done,
  input  logic       ack,
  output logic       irq,
  output logic       edge_flag,
  output logic       level_wake
);
  logic   pin_sync;
  sense_t mode_q;
  logic   samp_cur;
  logic   edge_hit;
  logic   spur;
  logic   lvl_req;
  logic   flag_set;

  extint_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_async),
    .dout(pin_sync)
  );

  extint_detect #(.IDLE_LEVEL(IDLE_LEVEL)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .sense_mode(sense_mode),
    .local_en  (local_en),
    .insn_done (insn_done),
    .mode_q    (mode_q),
    .samp_cur  (samp_cur),
    .edge_hit  (edge_hit),
    .spur      (spur),
    .lvl_req   (lvl_req)
  );

  assign flag_set = edge_hit | spur;

  extint_flag u_flag (
    .clk (clk),
    .rst (rst),
    .set (flag_set),
    .clr (ack),
    .flag(edge_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= global_ie & local_en & (edge_flag | lvl_req);
  end

  // Deliberately unclocked: usable while the CPU clock is stopped
  assign level_wake = local_en & (sense_mode == SENSE_LOW) & ~pin_async;
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk
  import extint_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   ack,
  input logic   global_ie,
  input logic   local_en,
  input logic   irq,
  input logic   edge_flag,
  input sense_t mode_q,
  input logic   samp_cur,
  input logic   edge_hit,
  input logic   flag_set,
  input logic   lvl_req
);
  // R4: reserved code never detects an edge
  a_r4_rsvd_no_edge: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SENSE_RSVD) |-> !edge_hit);

  // R5: low-level mode never feeds the edge flag from the line
  a_r5_low_no_edge: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SENSE_LOW) |-> !edge_hit);

  // R5: a level request requires a low sample in low-level mode one cycle earlier
  a_r5_lvl_needs_low: assert property (@(posedge clk) disable iff (rst)
    lvl_req |-> $past(mode_q == SENSE_LOW && !samp_cur));

  // R7: request only with both enables set in the previous cycle
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(global_ie && local_en));

  // R8: acknowledge clears the flag when nothing sets it
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (edge_flag && ack && !flag_set) |=> !edge_flag);

  // R8: setting wins over a simultaneous acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> edge_flag);
endmodule

bind extint_sense extint_sense_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .global_ie(global_ie),
  .local_en (local_en),
  .irq      (irq),
  .edge_flag(edge_flag),
  .mode_q   (mode_q),
  .samp_cur (samp_cur),
  .edge_hit (edge_hit),
  .flag_set (flag_set),
  .lvl_req  (lvl_req)
);

// File: tb/extint_sense_tb.sv
module extint_sense_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       pin_async;
  logic [1:0] sense_mode;
  logic       local_en;
  logic       global_ie;
  logic       insn_done;
  logic       ack;
  logic       irq;
  logic       edge_flag;
  logic       level_wake;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  extint_sense u_dut (
    .clk(clk), .rst(rst), .pin_async(pin_async), .sense_mode(sense_mode),
    .local_en(local_en), .global_ie(global_ie), .insn_done(insn_done),
    .ack(ack), .irq(irq), .edge_flag(edge_flag), .level_wake(level_wake)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0; step(1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1; pin_async = 1; sense_mode = 2'b10; local_en = 0;
    global_ie = 0; insn_done = 0; ack = 0;
    step(3);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 flag in reset", edge_flag, 1'b0);
    rst = 0; step(8);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 flag after reset", edge_flag, 1'b0);

    // R2 R3 R4 R5: sweep modes and both transition directions
    global_ie = 1;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic start_lvl;
        logic exp_f;
        start_lvl = (d == 0);
        local_en = 0; sense_mode = m[1:0]; pin_async = start_lvl;
        step(8); do_ack(); step(2);
        local_en = 1; step(2);
        pin_async = ~start_lvl; step(8);
        exp_f = (m == 2 && d == 0) || (m == 3 && d == 1);
        if (m == 2)      begin chk("R2 flag", edge_flag, exp_f); chk("R2 irq", irq, exp_f); end
        else if (m == 3) begin chk("R3 flag", edge_flag, exp_f); chk("R3 irq", irq, exp_f); end
        else if (m == 1) begin chk("R4 flag", edge_flag, 1'b0);  chk("R4 irq", irq, 1'b0); end
        else             begin chk("R5 flag", edge_flag, 1'b0);  chk("R6 irq", irq, 1'b0); end
      end
    end

    // R4: reserved with low line and instruction strobes
    local_en = 0; sense_mode = 2'b01; pin_async = 0; step(8); do_ack();
    local_en = 1; insn_done = 1; step(3); insn_done = 0; step(4);
    chk("R4 irq low+strobe", irq, 1'b0);
    chk("R4 flag low+strobe", edge_flag, 1'b0);

    // R5 R6: low level
    local_en = 0; pin_async = 1; sense_mode = 2'b00; step(8); do_ack();
    local_en = 1; pin_async = 0; step(10);
    chk("R6 no strobe", irq, 1'b0);
    insn_done = 1; step(1); insn_done = 0; step(2);
    chk("R5 armed", irq, 1'b1);
    step(20);
    chk("R5 held low", irq, 1'b1);
    chk("R5 no flag", edge_flag, 1'b0);
    pin_async = 1; step(8);
    chk("R5 released", irq, 1'b0);
    insn_done = 1; step(1); insn_done = 0; step(3);
    chk("R5 strobe high line", irq, 1'b0);

    // R7: gating sweep with the flag set
    local_en = 0; sense_mode = 2'b10; step(4); local_en = 1; step(2);
    pin_async = 0; step(8); pin_async = 1; step(8);
    for (int g = 0; g < 4; g++) begin
      global_ie = g[1]; local_en = g[0]; step(3);
      chk("R7 gate", irq, g[1] & g[0]);
    end
    global_ie = 1; local_en = 1;

    // R8: ack clears
    do_ack(); step(2);
    chk("R8 ack clears", edge_flag, 1'b0);
    chk("R8 irq after ack", irq, 1'b0);

    // R12 and R8 priority: fall just after an edge
    pin_async = 0; step(3);
    chk("R12 flag before 4th edge", edge_flag, 1'b0);
    ack = 1; step(1); ack = 0;
    chk("R12 flag at 4th edge", edge_flag, 1'b1);
    chk("R8 set wins over ack", edge_flag, 1'b1);
    chk("R12 irq before 5th edge", irq, 1'b0);
    step(1);
    chk("R12 irq at 5th edge", irq, 1'b1);
    pin_async = 1; step(8); do_ack(); step(2);

    // R9: two-cycle pulses in both edge modes
    pin_async = 0; step(2); pin_async = 1; step(8);
    chk("R9 fall pulse", edge_flag, 1'b1);
    local_en = 0; sense_mode = 2'b11; step(4); do_ack(); local_en = 1; step(2);
    pin_async = 0; step(8); do_ack();
    chk("R9 clean before pulse", edge_flag, 1'b0);
    pin_async = 1; step(2); pin_async = 0; step(8);
    chk("R9 rise pulse", edge_flag, 1'b1);
    pin_async = 1; step(8); do_ack(); step(2);

    // R10: mode change while enabled vs disabled
    sense_mode = 2'b10; step(3);
    chk("R10 change enabled", edge_flag, 1'b1);
    do_ack(); local_en = 0; sense_mode = 2'b11; step(4);
    chk("R10 change disabled flag", edge_flag, 1'b0);
    chk("R10 change disabled irq", irq, 1'b0);
    local_en = 1; step(3);
    chk("R10 enable afterwards", irq, 1'b0);

    // R11: unclocked wake
    local_en = 0; sense_mode = 2'b00; step(2); local_en = 1;
    pin_async = 0; #1;
    chk("R11 wake low", level_wake, 1'b1);
    pin_async = 1; #1;
    chk("R11 wake high", level_wake, 1'b0);
    pin_async = 0; local_en = 0; #1;
    chk("R11 wake disabled", level_wake, 1'b0);
    sense_mode = 2'b10; local_en = 1; #1;
    chk("R11 wake edge mode", level_wake, 1'b0);

    if (!finished) begin
      finished = 1;
      report();
    end
  end
endmodule